// File: doc/BRIEF.md
# Filtered Event Counter Bank

This block is a bank of ten independent 32-bit event counters behind a simple register read/write port. Counters 0 to 7 form a half-rate group that can advance only on every second clock edge. Counters 8 and 9 form a full-rate group that can advance on every edge. Each group has its own event input bus. That bus carries one active flag per event, a per-event amount field, and a shared 64-bit attribute word.

Each counter picks one event through its control word. The counter advances only while that event is active and the attribute word passes the counter's own mask/match qualifier. An invert bit flips the qualifier's result. The increment is selected per counter.

When a counter wraps, it latches a bit in the overflow status register of its group. The interrupt line stays high while any latched bit remains. Software drops the latched bits by writing zero to the status register.

Top module: `evc_bank`

## Requirements
- R1: After reset, every mask, match, control and count register reads zero, both status registers read zero and `irq` is low.
- R2: Counter n owns a register group at byte address 0x10 + 0x28·n. Mask low/high words sit at +0x00/+0x04, match low/high at +0x08/+0x0C, control at +0x10 and count at +0x20. All of these read back what was written. The control word keeps only bits 8:0, and its upper bits read as zero.
- R3: The control word fields are: bit 0 enable, bit 1 invert, bits 6:2 event select, bits 8:7 increment select. An enabled full-rate counter adds the selected amount on each edge where its event is active and qualified. Select 0 adds 1, select 1 adds 2, select 2 adds 3, and select 3 adds the selected event's 4-bit amount field, which is field k at bits 4k+3:4k of the amount bus.
- R4: Counters 0 to 7 advance at most once per two clock edges. Over any 2N consecutive edges with the event held active, such a counter advances exactly N times.
- R5: The qualifier is true when (attr & mask) == (match & mask), using all 64 bits. Setting the invert bit counts exactly the cycles in which that test is false.
- R6: An active event other than the one chosen by the event select field leaves the count unchanged.
- R7: With the enable bit clear, the count holds its value, and counting resumes from that value when the bit is set again.
- R8: The count register can be written with any value. A count write on the same edge as an increment takes the written value.
- R9: A wrap past 0xFFFFFFFF leaves the wrapped sum and sets the counter's status bit on that same edge. The half-rate status is at 0x08, bit i for counter i. The full-rate status is at 0x0C, bit j for counter 8+j.
- R10: Writing zero to a status register clears all of its bits, and a nonzero write leaves it unchanged. An overflow on the same edge as a clearing write still leaves its bit set.
- R11: `irq` is high exactly while some status bit in either register is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both groups |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| half_evt | input | 32 | Active flags of the half-rate group's events |
| half_amt | input | 128 | Per-event 4-bit amounts, half-rate group |
| half_attr | input | 64 | Attribute word for half-rate qualifiers |
| full_evt | input | 32 | Active flags of the full-rate group's events |
| full_amt | input | 128 | Per-event 4-bit amounts, full-rate group |
| full_attr | input | 64 | Attribute word for full-rate qualifiers |
| irq | output | 1 | High while any overflow status bit is set |

## Verification
Two operations can land on the same clock edge. The first pair is a status register clear and a wrap of a different counter in the same group. The bench sets up this collision by preloading counter 9 to all ones while counter 8's status bit is already set. It then drives the clearing write and the event pulse into the same cycle. The result is correct only if the full-rate status afterwards reads 0x2: the old bit is gone and the new one is latched.

The second pair is a count write and an increment. The bench holds the selected event active while writing the count, and requires the written value to appear unmodified.

// File: rtl/evc_pkg.sv
package evc_pkg;

   localparam int DATA_W   = 32;
   localparam int EVSEL_W  = 5;
   localparam int NUM_EVT  = 1 << EVSEL_W;
   localparam int INCR_W   = 2;
   localparam int OFF_W    = 6;

   // register group layout (byte offsets within a counter group)
   localparam logic [OFF_W-1:0] OFF_MASK_LO  = 6'h00;
   localparam logic [OFF_W-1:0] OFF_MASK_HI  = 6'h04;
   localparam logic [OFF_W-1:0] OFF_MATCH_LO = 6'h08;
   localparam logic [OFF_W-1:0] OFF_MATCH_HI = 6'h0C;
   localparam logic [OFF_W-1:0] OFF_CTRL     = 6'h10;
   localparam logic [OFF_W-1:0] OFF_COUNT    = 6'h20;

   localparam int GRP_BASE     = 'h10;
   localparam int GRP_STRIDE   = 'h28;
   localparam int ST_HALF_ADDR = 'h08;
   localparam int ST_FULL_ADDR = 'h0C;

   // increment select codes
   localparam logic [INCR_W-1:0] INC_ONE   = 2'd0;
   localparam logic [INCR_W-1:0] INC_TWO   = 2'd1;
   localparam logic [INCR_W-1:0] INC_THREE = 2'd2;
   localparam logic [INCR_W-1:0] INC_AMT   = 2'd3;

   typedef struct packed {
      logic [INCR_W-1:0]  incr;
      logic [EVSEL_W-1:0] evsel;
      logic               inv;
      logic               en;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/evc_rate_div.sv
module evc_rate_div #(
   parameter int RATIO = 2
)(
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int PH_W = (RATIO > 1) ? $clog2(RATIO) : 1;
   localparam logic [PH_W-1:0] LAST = PH_W'(RATIO - 1);

   if (RATIO < 2) begin : g_bad_ratio
      $error("evc_rate_div: RATIO must be at least 2");
   end

   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ph_q <= '0;
      else if (ph_q == LAST) ph_q <= '0;
      else                   ph_q <= ph_q + 1'b1;
   end

   assign tick_o = (ph_q == LAST);

endmodule

// File: rtl/evc_counter.sv
module evc_counter
   import evc_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int QUAL_W = 64,
   parameter int AMT_W  = 4
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   input  logic                     grp_we,
   input  logic                     cnt_we,
   input  logic [OFF_W-1:0]         off,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [NUM_EVT-1:0]       evt,
   input  logic [NUM_EVT*AMT_W-1:0] amt,
   input  logic [QUAL_W-1:0]        attr,
   output logic [DATA_W-1:0]        rd_o,
   output logic                     ovf_o,
   output logic [CNT_W-1:0]         cnt_o,
   output logic                     en_o
);
   localparam int HI_W = QUAL_W - DATA_W;

   ctrl_t              ctrl_q;
   logic [QUAL_W-1:0]  mask_q;
   logic [QUAL_W-1:0]  match_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [AMT_W-1:0]   amt_arr [NUM_EVT];
   logic [CNT_W-1:0]   inc_v;
   logic [CNT_W:0]     sum;
   logic               hit;
   logic               active;
   logic               count_now;

   for (genvar k = 0; k < NUM_EVT; k++) begin : g_amt
      assign amt_arr[k] = amt[k*AMT_W +: AMT_W];
   end

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q  <= '0;
         match_q <= '0;
         ctrl_q  <= '0;
      end else if (grp_we) begin
         case (off)
            OFF_MASK_LO:  mask_q[DATA_W-1:0]       <= wdata;
            OFF_MASK_HI:  mask_q[QUAL_W-1:DATA_W]  <= wdata[HI_W-1:0];
            OFF_MATCH_LO: match_q[DATA_W-1:0]      <= wdata;
            OFF_MATCH_HI: match_q[QUAL_W-1:DATA_W] <= wdata[HI_W-1:0];
            OFF_CTRL:     ctrl_q                   <= ctrl_t'(wdata[CTRL_W-1:0]);
            default: ;
         endcase
      end
   end

   // qualifier and increment
   assign hit       = ((attr & mask_q) == (match_q & mask_q)) ^ ctrl_q.inv;
   assign active    = evt[ctrl_q.evsel];
   assign count_now = tick & ctrl_q.en & active & hit;

   always_comb begin
      inc_v = '0;
      case (ctrl_q.incr)
         INC_ONE:   inc_v[1:0] = 2'd1;
         INC_TWO:   inc_v[1:0] = 2'd2;
         INC_THREE: inc_v[1:0] = 2'd3;
         default:   inc_v[AMT_W-1:0] = amt_arr[ctrl_q.evsel];
      endcase
   end

   assign sum = {1'b0, cnt_q} + {1'b0, inc_v};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (cnt_we)    cnt_q <= wdata[CNT_W-1:0];
      else if (count_now) cnt_q <= sum[CNT_W-1:0];
   end

   assign ovf_o = count_now & sum[CNT_W] & ~cnt_we;
   assign cnt_o = cnt_q;
   assign en_o  = ctrl_q.en;

   always_comb begin
      rd_o = '0;
      case (off)
         OFF_MASK_LO:  rd_o              = mask_q[DATA_W-1:0];
         OFF_MASK_HI:  rd_o[HI_W-1:0]    = mask_q[QUAL_W-1:DATA_W];
         OFF_MATCH_LO: rd_o              = match_q[DATA_W-1:0];
         OFF_MATCH_HI: rd_o[HI_W-1:0]    = match_q[QUAL_W-1:DATA_W];
         OFF_CTRL:     rd_o[CTRL_W-1:0]  = ctrl_q;
         OFF_COUNT:    rd_o[CNT_W-1:0]   = cnt_q;
         default: ;
      endcase
   end

endmodule

// File: rtl/evc_bank.sv
module evc_bank
   import evc_pkg::*;
#(
   parameter int NUM_HALF   = 8,
   parameter int NUM_FULL   = 2,
   parameter int CNT_W      = 32,
   parameter int QUAL_W     = 64,
   parameter int AMT_W      = 4,
   parameter int ADDR_W     = 12,
   parameter int HALF_RATIO = 2
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_we,
   input  logic [ADDR_W-1:0]        reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   input  logic [NUM_EVT-1:0]       half_evt,
   input  logic [NUM_EVT*AMT_W-1:0] half_amt,
   input  logic [QUAL_W-1:0]        half_attr,
   input  logic [NUM_EVT-1:0]       full_evt,
   input  logic [NUM_EVT*AMT_W-1:0] full_amt,
   input  logic [QUAL_W-1:0]        full_attr,
   output logic                     irq
);
   localparam int NUM_CNT   = NUM_HALF + NUM_FULL;
   localparam int LAST_ADDR = GRP_BASE + GRP_STRIDE * NUM_CNT - 1;
   localparam logic [ADDR_W-1:0] ST_HALF_A = ADDR_W'(ST_HALF_ADDR);
   localparam logic [ADDR_W-1:0] ST_FULL_A = ADDR_W'(ST_FULL_ADDR);

   // elaboration-time parameter checks
   if (NUM_HALF < 1 || NUM_HALF > DATA_W) begin : g_bad_half
      $error("evc_bank: NUM_HALF out of range");
   end
   if (NUM_FULL < 1 || NUM_FULL > DATA_W) begin : g_bad_full
      $error("evc_bank: NUM_FULL out of range");
   end
   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("evc_bank: ADDR_W too small for the counter groups");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("evc_bank: CNT_W out of range");
   end
   if (QUAL_W <= DATA_W || QUAL_W > 2 * DATA_W) begin : g_bad_qual
      $error("evc_bank: QUAL_W must span two words");
   end
   if (AMT_W < 1 || AMT_W > CNT_W) begin : g_bad_amt
      $error("evc_bank: AMT_W out of range");
   end

   logic                               half_tick;
   logic [NUM_CNT-1:0]                 in_grp;
   logic [NUM_CNT-1:0]                 cnt_wr_all;
   logic [NUM_CNT-1:0]                 ovf_all;
   logic [NUM_CNT-1:0]                 en_all;
   logic [NUM_CNT-1:0][CNT_W-1:0]      cnt_all;
   logic [NUM_CNT-1:0][DATA_W-1:0]     rd_all;
   logic [NUM_CNT-1:0][OFF_W-1:0]      off_all;
   logic [NUM_HALF-1:0]                st_half;
   logic [NUM_FULL-1:0]                st_full;
   logic                               st_half_wr, st_full_wr;
   logic                               st_half_clr, st_full_clr;

   evc_rate_div #(.RATIO(HALF_RATIO)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (half_tick)
   );

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(GRP_BASE + GRP_STRIDE * i);
      logic [ADDR_W-1:0] rel;

      assign rel           = reg_addr - BASE_A;
      assign in_grp[i]     = (reg_addr >= BASE_A) && (rel < ADDR_W'(GRP_STRIDE));
      assign off_all[i]    = rel[OFF_W-1:0];
      assign cnt_wr_all[i] = reg_we && in_grp[i] && (off_all[i] == OFF_COUNT);

      if (i < NUM_HALF) begin : g_half
         evc_counter #(.CNT_W(CNT_W), .QUAL_W(QUAL_W), .AMT_W(AMT_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (half_tick),
            .grp_we (reg_we && in_grp[i]),
            .cnt_we (cnt_wr_all[i]),
            .off    (off_all[i]),
            .wdata  (reg_wdata),
            .evt    (half_evt),
            .amt    (half_amt),
            .attr   (half_attr),
            .rd_o   (rd_all[i]),
            .ovf_o  (ovf_all[i]),
            .cnt_o  (cnt_all[i]),
            .en_o   (en_all[i])
         );
      end else begin : g_full
         evc_counter #(.CNT_W(CNT_W), .QUAL_W(QUAL_W), .AMT_W(AMT_W)) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (1'b1),
            .grp_we (reg_we && in_grp[i]),
            .cnt_we (cnt_wr_all[i]),
            .off    (off_all[i]),
            .wdata  (reg_wdata),
            .evt    (full_evt),
            .amt    (full_amt),
            .attr   (full_attr),
            .rd_o   (rd_all[i]),
            .ovf_o  (ovf_all[i]),
            .cnt_o  (cnt_all[i]),
            .en_o   (en_all[i])
         );
      end
   end

   // overflow status, one register per rate group
   assign st_half_wr  = reg_we && (reg_addr == ST_HALF_A);
   assign st_full_wr  = reg_we && (reg_addr == ST_FULL_A);
   assign st_half_clr = st_half_wr && (reg_wdata == '0);
   assign st_full_clr = st_full_wr && (reg_wdata == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_half <= '0;
         st_full <= '0;
      end else begin
         st_half <= (st_half_clr ? '0 : st_half) | ovf_all[NUM_HALF-1:0];
         st_full <= (st_full_clr ? '0 : st_full) | ovf_all[NUM_CNT-1:NUM_HALF];
      end
   end

   assign irq = (|st_half) | (|st_full);

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ST_HALF_A) reg_rdata[NUM_HALF-1:0] = st_half;
      if (reg_addr == ST_FULL_A) reg_rdata[NUM_FULL-1:0] = st_full;
      for (int k = 0; k < NUM_CNT; k++) begin
         if (in_grp[k]) reg_rdata = reg_rdata | rd_all[k];
      end
   end

endmodule

// File: rtl/evc_bank_chk.sv
module evc_bank_chk #(
   parameter int NUM_HALF = 8,
   parameter int NUM_FULL = 2,
   parameter int CNT_W    = 32
)(
   input logic                                  clk,
   input logic                                  rst_n,
   input logic                                  half_tick,
   input logic [NUM_HALF+NUM_FULL-1:0][CNT_W-1:0] cnt_all,
   input logic [NUM_HALF+NUM_FULL-1:0]          en_all,
   input logic [NUM_HALF+NUM_FULL-1:0]          cnt_wr_all,
   input logic [NUM_HALF+NUM_FULL-1:0]          ovf_all,
   input logic [NUM_HALF-1:0]                   st_half,
   input logic [NUM_FULL-1:0]                   st_full,
   input logic                                  st_half_clr,
   input logic                                  st_full_clr,
   input logic                                  irq
);
   localparam int NUM_CNT = NUM_HALF + NUM_FULL;

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_each
      // R7: a disabled counter that is not written keeps its value
      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_all[i] && !cnt_wr_all[i]) |=> (cnt_all[i] == $past(cnt_all[i])));

      // R9: a wrap latches the status bit of that counter
      if (i < NUM_HALF) begin : g_h
         p_ovf_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_all[i] |=> st_half[i]);
         // R4: half-rate counters move only on rate ticks or writes
         p_half_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!half_tick && !cnt_wr_all[i]) |=> $stable(cnt_all[i]));
      end else begin : g_f
         p_ovf_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_all[i] |=> st_full[i-NUM_HALF]);
      end
   end

   // R10: without a clearing write, latched bits stay set
   p_sticky_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !st_half_clr |=> ((st_half & $past(st_half)) == $past(st_half)));
   p_sticky_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !st_full_clr |=> ((st_full & $past(st_full)) == $past(st_full)));

   // R10: a clearing write with no simultaneous wrap empties the register
   p_clear_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_half_clr && !(|ovf_all[NUM_HALF-1:0])) |=> (st_half == '0));
   p_clear_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_full_clr && !(|ovf_all[NUM_CNT-1:NUM_HALF])) |=> (st_full == '0));

   // R11: the interrupt only rises after some counter wrapped
   p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|ovf_all));

endmodule

bind evc_bank evc_bank_chk #(
   .NUM_HALF (NUM_HALF),
   .NUM_FULL (NUM_FULL),
   .CNT_W    (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .half_tick   (half_tick),
   .cnt_all     (cnt_all),
   .en_all      (en_all),
   .cnt_wr_all  (cnt_wr_all),
   .ovf_all     (ovf_all),
   .st_half     (st_half),
   .st_full     (st_full),
   .st_half_clr (st_half_clr),
   .st_full_clr (st_full_clr),
   .irq         (irq)
);

// File: tb/evc_bank_tb.sv
module evc_bank_tb;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         reg_we;
   logic [11:0]  reg_addr;
   logic [31:0]  reg_wdata;
   logic [31:0]  reg_rdata;
   logic [31:0]  half_evt, full_evt;
   logic [127:0] half_amt, full_amt;
   logic [63:0]  half_attr, full_attr;
   logic         irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   evc_bank u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .half_evt  (half_evt),
      .half_amt  (half_amt),
      .half_attr (half_attr),
      .full_evt  (full_evt),
      .full_amt  (full_amt),
      .full_attr (full_attr),
      .irq       (irq)
   );

   function automatic logic [11:0] ga(input int n, input int off);
      return 12'(16 + 40 * n + off);
   endfunction

   function automatic logic [31:0] ctl(input int incr, input int sel, input bit inv, input bit en);
      return 32'((incr << 7) | (sel << 2) | (int'(inv) << 1) | int'(en));
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1 chk(req, reg_rdata, exp);
   endtask

   task automatic pulse_full(input int ev, input int n);
      @(negedge clk);
      full_evt[ev] = 1'b1;
      repeat (n) @(negedge clk);
      full_evt[ev] = 1'b0;
   endtask

   task automatic pulse_half(input int ev, input int n);
      @(negedge clk);
      half_evt[ev] = 1'b1;
      repeat (n) @(negedge clk);
      half_evt[ev] = 1'b0;
   endtask

   task automatic t_reset;
      rd_chk("R1 count0", ga(0, 'h20), 32'h0);
      rd_chk("R1 ctrl9", ga(9, 'h10), 32'h0);
      rd_chk("R1 maskhi3", ga(3, 'h04), 32'h0);
      rd_chk("R1 st_half", 12'h008, 32'h0);
      rd_chk("R1 st_full", 12'h00C, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);
   endtask

   task automatic t_regmap;
      wr(ga(3, 'h00), 32'hA5A5_0001);
      wr(ga(3, 'h04), 32'h1234_5678);
      wr(ga(3, 'h08), 32'hDEAD_BEEF);
      wr(ga(3, 'h0C), 32'h0BAD_F00D);
      wr(ga(3, 'h10), 32'hFFFF_FFFE);
      rd_chk("R2 mask lo", ga(3, 'h00), 32'hA5A5_0001);
      rd_chk("R2 mask hi", ga(3, 'h04), 32'h1234_5678);
      rd_chk("R2 match lo", ga(3, 'h08), 32'hDEAD_BEEF);
      rd_chk("R2 match hi", ga(3, 'h0C), 32'h0BAD_F00D);
      rd_chk("R2 ctrl 9 bits", ga(3, 'h10), 32'h0000_01FE);
      wr(ga(3, 'h10), 32'h0);
   endtask

   task automatic t_full_inc;
      wr(ga(8, 'h10), ctl(0, 2, 0, 1));
      pulse_full(2, 5);
      rd_chk("R3 incr one", ga(8, 'h20), 32'd5);
      wr(ga(8, 'h20), 32'h0);
      wr(ga(8, 'h10), ctl(1, 2, 0, 1));
      pulse_full(2, 3);
      rd_chk("R3 incr two", ga(8, 'h20), 32'd6);
      wr(ga(8, 'h20), 32'h0);
      wr(ga(8, 'h10), ctl(2, 2, 0, 1));
      pulse_full(2, 4);
      rd_chk("R3 incr three", ga(8, 'h20), 32'd12);
      wr(ga(8, 'h20), 32'h0);
      full_amt[2*4 +: 4] = 4'd7;
      wr(ga(8, 'h10), ctl(3, 2, 0, 1));
      pulse_full(2, 2);
      rd_chk("R3 incr amount", ga(8, 'h20), 32'd14);
   endtask

   task automatic t_half;
      wr(ga(1, 'h10), ctl(0, 0, 0, 1));
      pulse_half(0, 10);
      rd_chk("R4 half rate", ga(1, 'h20), 32'd5);
   endtask

   task automatic t_filter;
      wr(ga(9, 'h00), 32'h0000_00FF);
      wr(ga(9, 'h08), 32'h0000_002F);
      wr(ga(9, 'h10), ctl(0, 1, 0, 1));
      full_attr = 64'h12F;
      pulse_full(1, 4);
      rd_chk("R5 match counts", ga(9, 'h20), 32'd4);
      full_attr = 64'h130;
      pulse_full(1, 4);
      rd_chk("R5 mismatch ignored", ga(9, 'h20), 32'd4);
      wr(ga(9, 'h10), ctl(0, 1, 1, 1));
      pulse_full(1, 3);
      rd_chk("R5 invert mismatch counts", ga(9, 'h20), 32'd7);
      full_attr = 64'h12F;
      pulse_full(1, 3);
      rd_chk("R5 invert match ignored", ga(9, 'h20), 32'd7);
      wr(ga(9, 'h10), ctl(0, 1, 0, 1));
      wr(ga(9, 'h04), 32'h1);
      wr(ga(9, 'h0C), 32'h1);
      pulse_full(1, 2);
      rd_chk("R5 high word mismatch", ga(9, 'h20), 32'd7);
      full_attr = 64'h1_0000_012F;
      pulse_full(1, 2);
      rd_chk("R5 high word match", ga(9, 'h20), 32'd9);
   endtask

   task automatic t_select;
      wr(ga(8, 'h20), 32'h0);
      wr(ga(8, 'h10), ctl(0, 5, 0, 1));
      pulse_full(4, 6);
      rd_chk("R6 other event ignored", ga(8, 'h20), 32'd0);
      pulse_full(5, 2);
      rd_chk("R6 selected event", ga(8, 'h20), 32'd2);
   endtask

   task automatic t_hold;
      wr(ga(8, 'h10), 32'h0);
      pulse_full(5, 4);
      rd_chk("R7 disabled holds", ga(8, 'h20), 32'd2);
      wr(ga(8, 'h10), ctl(0, 5, 0, 1));
      pulse_full(5, 1);
      rd_chk("R7 resumes", ga(8, 'h20), 32'd3);
   endtask

   task automatic t_wr_prio;
      @(negedge clk);
      full_evt[5] = 1'b1;
      @(negedge clk);
      reg_we = 1'b1; reg_addr = ga(8, 'h20); reg_wdata = 32'h100;
      @(negedge clk);
      reg_we = 1'b0; full_evt[5] = 1'b0;
      #1 chk("R8 write beats increment", reg_rdata, 32'h100);
      wr(ga(8, 'h20), 32'h8000_0000);
      rd_chk("R8 preload", ga(8, 'h20), 32'h8000_0000);
   endtask

   task automatic t_wrap;
      wr(ga(8, 'h20), 32'hFFFF_FFFE);
      pulse_full(5, 2);
      rd_chk("R9 wrapped value", ga(8, 'h20), 32'h0);
      rd_chk("R9 full status bit0", 12'h00C, 32'h1);
      rd_chk("R9 half status clean", 12'h008, 32'h0);
      chk("R11 irq set", {31'h0, irq}, 32'h1);
      wr(ga(2, 'h10), ctl(0, 0, 0, 1));
      wr(ga(2, 'h20), 32'hFFFF_FFFF);
      pulse_half(0, 2);
      rd_chk("R9 half wrap value", ga(2, 'h20), 32'h0);
      rd_chk("R9 half status bit2", 12'h008, 32'h4);
   endtask

   task automatic t_clear;
      wr(12'h008, 32'h5);
      rd_chk("R10 nonzero write ignored", 12'h008, 32'h4);
      wr(12'h008, 32'h0);
      rd_chk("R10 zero write clears", 12'h008, 32'h0);
      chk("R11 irq from full group", {31'h0, irq}, 32'h1);
      wr(ga(9, 'h00), 32'h0);
      wr(ga(9, 'h04), 32'h0);
      wr(ga(9, 'h10), ctl(0, 5, 0, 1));
      wr(ga(9, 'h20), 32'hFFFF_FFFF);
      @(negedge clk);
      full_evt[5] = 1'b1;
      reg_we = 1'b1; reg_addr = 12'h00C; reg_wdata = 32'h0;
      @(negedge clk);
      full_evt[5] = 1'b0; reg_we = 1'b0;
      rd_chk("R10 clear and wrap same edge", 12'h00C, 32'h2);
      chk("R11 irq stays", {31'h0, irq}, 32'h1);
      wr(12'h00C, 32'h0);
      rd_chk("R10 full cleared", 12'h00C, 32'h0);
      chk("R11 irq low", {31'h0, irq}, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R1 act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      half_evt = '0; full_evt = '0; half_amt = '0; full_amt = '0;
      half_attr = '0; full_attr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_regmap;
      t_full_inc;
      t_half;
      t_filter;
      t_select;
      t_hold;
      t_wr_prio;
      t_wrap;
      t_clear;
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule